// File: doc/BRIEF.md
# Serial Master with Slave-Ready Handshake

This block is a serial shift engine that drives clock, chip select and data toward one slave, using clock mode 0. The clock idles low. Data changes on the falling edge and is sampled on the rising edge, most significant bit first. Before any bits move, the engine can wait for the slave to pull an active-low ready line. It can also check that line while the bits are shifting, and abort a character that the slave cuts short.

After `start` is accepted, chip select goes low and the engine enters a wait phase. When the wait-enable input is set and the ready line is high, a bounded window runs. If the slave never answers in that window, the engine raises a timeout flag and releases chip select without shifting anything. A delay count of zero makes the wait unbounded. During shifting, the ready line going high raises a sticky length-error flag, but only when the ready pin is configured as functional. The character is then dropped. Both flags stay set until `err_clr` clears them.

A run-enable input acts as a module-level reset: when it is low the whole engine is held in its reset state. A power-down input holds off new transfers while it is high.

Top module: `spi_hs_master`

## Requirements
- R1: While `rst` is high, or while `run_en` is low, the engine is in its reset state: `cs_n`=1, `sclk`=0, `busy`=0, `rx_valid`=0, `len_err`=0, `to_err`=0. A `start` pulse given with `run_en` low is ignored.
- R2: The clock idles at 0 and each half period lasts `cfg_prescale`+1 module clock cycles. `mosi` shifts out the `cfg_len` low bits of `tx_data`, most significant first, and is stable while `sclk` is high. `miso` is sampled on each rising `sclk` edge.
- R3: If the engine does not wait, `cs_n` stays low for exactly 1 + 2·`cfg_len`·(`cfg_prescale`+1) cycles. `rx_valid` is high for exactly the one cycle in which `cs_n` first returns high. In that cycle `rx_data` holds the received bits right-aligned, with the upper bits 0.
- R4: Suppose `cfg_wait_en`=1, `cfg_c2e_dly`=D>0 and `ena_n` is high when the wait begins and stays high. Then `cs_n` is low for exactly D·(`cfg_prescale`+2) cycles, `to_err` is set, and `sclk` never rises. `rx_valid` stays 0.
- R5: If `cfg_wait_en`=1 and `cfg_c2e_dly`=0, the engine waits with `cs_n` low for as long as `ena_n` stays high. Once `ena_n` goes low, the character completes normally.
- R6: If `cfg_wait_en`=0, the engine ignores `ena_n` at the start of a transfer: the character shifts at once and no timeout occurs.
- R7: If `cfg_ena_func`=1 and `ena_n` is high in a cycle while bits are shifting, the engine sets `len_err`. In the same cycle `cs_n` returns high and `sclk` returns low. No `rx_valid` is produced for that character.
- R8: If `cfg_ena_func`=0, `ena_n` going high in the middle of a character has no effect: the character completes and `len_err` stays 0.
- R9: `len_err` and `to_err` stay set until a cycle with `err_clr`=1 clears both.
- R10: While `power_down` is high, `start` is ignored in idle: `cs_n` stays high and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Module run enable; 0 holds the engine in reset |
| power_down | input | 1 | Holds off new transfers while high |
| cfg_len | input | LEN_W | Character length in bits, 1..MAX_LEN |
| cfg_prescale | input | PRE_W | Half-period length minus one, in module clocks |
| cfg_wait_en | input | 1 | Wait for slave ready before shifting |
| cfg_c2e_dly | input | DLY_W | Wait window in units of prescale+2 cycles; 0 = unbounded |
| cfg_ena_func | input | 1 | Ready pin is functional; enables the length-error check |
| start | input | 1 | Begin a transfer (sampled in idle) |
| tx_data | input | MAX_LEN | Character to send, right-aligned |
| err_clr | input | 1 | Clears both error flags |
| miso | input | 1 | Serial data from slave |
| ena_n | input | 1 | Active-low slave ready |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Engine not idle |
| rx_data | output | MAX_LEN | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when a character completes |
| len_err | output | 1 | Sticky length-error flag |
| to_err | output | 1 | Sticky ready-timeout flag |

## Verification
The hardest case to reach is a ready line that is released after a chosen rising clock edge inside a character. Only that case shows whether the abort releases chip select in the next cycle and suppresses the receive pulse. To get there, the bench acts as the slave: it counts rising `sclk` edges as it samples and raises `ena_n` right after a chosen edge. It then measures how long chip select was low. The unbounded wait is reached by holding `ena_n` high for hundreds of cycles with a zero delay count, then releasing it and timing the rest of the character.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } hs_state_e;
endpackage

// File: rtl/spi_hs_phase.sv
// Half-period timer: tick marks the last cycle of each clock phase.
module spi_hs_phase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (clr || tick) cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_hs_tmo.sv
// Ready-wait window: dly units of (pre+2) cycles each.
module spi_hs_tmo #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] pre,
  input  logic [DW-1:0] dly,
  output logic          expire
);
  logic [PW:0]   ps;
  logic [DW-1:0] unit;
  logic [PW:0]   unit_len;
  logic          unit_end;

  assign unit_len = {1'b0, pre} + 1'b1;
  assign unit_end = (ps == unit_len);
  assign expire   = en && (dly != '0) && unit_end && (unit == dly - 1'b1);

  always_ff @(posedge clk) begin
    if (clr) begin
      ps   <= '0;
      unit <= '0;
    end else if (en) begin
      if (unit_end) begin
        ps   <= '0;
        unit <= unit + 1'b1;
      end else begin
        ps <= ps + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_hs_shreg.sv
// Transmit and receive shift registers; transmit word is left-aligned on load.
module spi_hs_shreg #(
  parameter int N  = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          load,
  input  logic [N-1:0]  tx,
  input  logic [LW-1:0] len,
  input  logic          shift_out,
  input  logic          sample,
  input  logic          miso,
  output logic          mosi_bit,
  output logic [N-1:0]  rx_word
);
  logic [N-1:0] tx_sh;

  assign mosi_bit = tx_sh[N-1];

  always_ff @(posedge clk) begin
    if (load) begin
      tx_sh   <= tx << (LW'(N) - len);
      rx_word <= '0;
    end else begin
      if (shift_out) tx_sh   <= {tx_sh[N-2:0], 1'b0};
      if (sample)    rx_word <= {rx_word[N-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int PRE_W   = 8,
  parameter int DLY_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               power_down,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic               cfg_wait_en,
  input  logic [DLY_W-1:0]   cfg_c2e_dly,
  input  logic               cfg_ena_func,
  input  logic               start,
  input  logic [MAX_LEN-1:0] tx_data,
  input  logic               err_clr,
  input  logic               miso,
  input  logic               ena_n,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               rx_valid,
  output logic               len_err,
  output logic               to_err
);
  hs_state_e          state;
  logic               srst;
  logic [LEN_W-1:0]   bit_cnt;
  logic               tick, expire, load, go_shift, abort_len, last_bit;
  logic               sample, shift_out, mosi_bit;
  logic [MAX_LEN-1:0] rx_word;

  assign srst      = rst || !run_en;
  assign load      = (state == ST_IDLE) && start && !power_down;
  assign go_shift  = (state == ST_WAIT) && (!cfg_wait_en || !ena_n);
  assign abort_len = (state == ST_SHIFT) && cfg_ena_func && ena_n;
  assign last_bit  = (bit_cnt == cfg_len - 1'b1);
  assign sample    = tick && !sclk && !abort_len;
  assign shift_out = tick && sclk && !last_bit && !abort_len;
  assign busy      = (state != ST_IDLE);
  assign mosi      = cs_n ? 1'b0 : mosi_bit;

  spi_hs_phase #(.W(PRE_W)) u_phase (
    .clk   (clk),
    .clr   (srst || state != ST_SHIFT),
    .en    (state == ST_SHIFT),
    .limit (cfg_prescale),
    .tick  (tick)
  );

  spi_hs_tmo #(.PW(PRE_W), .DW(DLY_W)) u_tmo (
    .clk    (clk),
    .clr    (srst || state != ST_WAIT),
    .en     ((state == ST_WAIT) && cfg_wait_en && ena_n),
    .pre    (cfg_prescale),
    .dly    (cfg_c2e_dly),
    .expire (expire)
  );

  spi_hs_shreg #(.N(MAX_LEN), .LW(LEN_W)) u_sh (
    .clk       (clk),
    .load      (load),
    .tx        (tx_data),
    .len       (cfg_len),
    .shift_out (shift_out),
    .sample    (sample),
    .miso      (miso),
    .mosi_bit  (mosi_bit),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      bit_cnt  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      len_err  <= 1'b0;
      to_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (err_clr) begin
        len_err <= 1'b0;
        to_err  <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (load) begin
            cs_n    <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (go_shift) begin
            state <= ST_SHIFT;
          end else if (expire) begin
            to_err <= 1'b1;
            cs_n   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (abort_len) begin
            len_err <= 1'b1;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            state   <= ST_IDLE;
          end else if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (last_bit) begin
                cs_n     <= 1'b1;
                rx_valid <= 1'b1;
                rx_data  <= rx_word;
                state    <= ST_IDLE;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_hs_master_chk.sv
module spi_hs_master_chk (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic power_down,
  input logic err_clr,
  input logic sclk,
  input logic cs_n,
  input logic busy,
  input logic rx_valid,
  input logic len_err,
  input logic to_err
);
  AST_RUN_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (cs_n && !busy && !len_err && !to_err)); // R1
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R2
  AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cs_n && !$past(cs_n))); // R3
  AST_LEN_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (run_en && $rose(len_err)) |-> (cs_n && !rx_valid)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (run_en && to_err && !err_clr) |=> (to_err || !run_en)); // R9
  AST_PD_NO_START: assert property (@(posedge clk) disable iff (rst)
    (run_en && power_down && !busy) |=> cs_n); // R10
endmodule

bind spi_hs_master spi_hs_master_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .power_down (power_down),
  .err_clr    (err_clr),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .busy       (busy),
  .rx_valid   (rx_valid),
  .len_err    (len_err),
  .to_err     (to_err)
);

// File: tb/sim_spi_hs_master.sv
`timescale 1ns/1ps
module sim_spi_hs_master;
  localparam int MAX_LEN = 16;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b1, power_down = 1'b0;
  logic [LEN_W-1:0] cfg_len = 5'd8;
  logic [7:0] cfg_prescale = 8'd1, cfg_c2e_dly = 8'd4;
  logic cfg_wait_en = 1'b1, cfg_ena_func = 1'b1;
  logic start = 1'b0, err_clr = 1'b0, miso = 1'b0, ena_n = 1'b0;
  logic [15:0] tx_data = '0;
  logic sclk, mosi, cs_n, busy, rx_valid, len_err, to_err;
  logic [15:0] rx_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_hs_master u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .power_down(power_down),
    .cfg_len(cfg_len), .cfg_prescale(cfg_prescale), .cfg_wait_en(cfg_wait_en),
    .cfg_c2e_dly(cfg_c2e_dly), .cfg_ena_func(cfg_ena_func), .start(start),
    .tx_data(tx_data), .err_clr(err_clr), .miso(miso), .ena_n(ena_n),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .rx_data(rx_data),
    .rx_valid(rx_valid), .len_err(len_err), .to_err(to_err)
  );

  // {len, prescale, tx word, slave reply}
  localparam logic [47:0] VEC [0:4] = '{
    {8'd8,  8'd1, 16'h00A5, 16'h003C},
    {8'd16, 8'd0, 16'hBEEF, 16'h1234},
    {8'd1,  8'd3, 16'h0001, 16'h0001},
    {8'd5,  8'd2, 16'h0013, 16'h000A},
    {8'd12, 8'd1, 16'h0F0F, 16'h0ABC}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Acts as the slave; ends on the negedge where cs_n is first seen high.
  int          cs_low, nrise, vcnt;
  logic [15:0] mgot, rxd;
  task automatic xfer(input int len, input logic [15:0] tx, input logic [15:0] rx,
                      input int drop_at, input int limit);
    logic prev = 1'b0;
    cs_low = 0; nrise = 0; vcnt = 0; mgot = '0; rxd = '0;
    @(negedge clk);
    cfg_len = LEN_W'(len);
    tx_data = tx;
    miso = rx[len-1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < limit; c++) begin
      if (cs_n) break;
      cs_low++;
      if (rx_valid) vcnt++;
      if (sclk && !prev) begin
        mgot = {mgot[14:0], mosi};
        nrise++;
        miso = (nrise < len) ? rx[len-1-nrise] : 1'b0;
        if (nrise == drop_at) ena_n = 1'b1;
      end
      prev = sclk;
      @(negedge clk);
    end
    if (rx_valid) begin
      vcnt++;
      rxd = rx_data;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !rx_valid, "R1 reset outputs", {cs_n, sclk, busy, rx_valid}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(!len_err && !to_err && cs_n, "R1 after reset", {len_err, to_err, cs_n}, 3'b001);

    // Vector table: wait enabled, slave already ready.
    for (int i = 0; i < 5; i++) begin
      int len, pre, exp_low;
      logic [15:0] msk;
      len = int'(VEC[i][47:40]);
      pre = int'(VEC[i][39:32]);
      cfg_prescale = VEC[i][39:32];
      cfg_wait_en = 1'b1; cfg_ena_func = 1'b1; ena_n = 1'b0; cfg_c2e_dly = 8'd4;
      msk = 16'((32'h1 << len) - 1);
      exp_low = 1 + 2 * len * (pre + 1);
      xfer(len, VEC[i][31:16], VEC[i][15:0], -1, 2000);
      chk((mgot & msk) == VEC[i][31:16], "R2 mosi bits", int'(mgot & msk), int'(VEC[i][31:16]));
      chk(rxd == VEC[i][15:0], "R3 rx_data", int'(rxd), int'(VEC[i][15:0]));
      chk(cs_low == exp_low, "R3 cs_n low length", cs_low, exp_low);
      chk(vcnt == 1, "R3 rx_valid pulse", vcnt, 1);
      @(negedge clk);
      chk(!rx_valid, "R3 rx_valid one cycle", rx_valid, 0);
    end

    // R4 timeout: dly 3, prescale 2 -> 12 cycles.
    cfg_prescale = 8'd2; cfg_c2e_dly = 8'd3; ena_n = 1'b1;
    xfer(8, 16'h00FF, 16'h0000, -1, 200);
    chk(cs_low == 12, "R4 wait window", cs_low, 12);
    chk(to_err, "R4 to_err", to_err, 1);
    chk(nrise == 0 && vcnt == 0, "R4 no shift", nrise + vcnt, 0);
    repeat (5) @(negedge clk);
    chk(to_err, "R9 to_err sticky", to_err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!to_err, "R9 to_err cleared", to_err, 0);

    // R5 unbounded wait, then ready.
    cfg_prescale = 8'd0; cfg_c2e_dly = 8'd0; ena_n = 1'b1;
    xfer(4, 16'h000A, 16'h0005, -1, 300);
    chk(cs_low == 300 && !cs_n && nrise == 0, "R5 still waiting", cs_low, 300);
    ena_n = 1'b0;
    begin
      int n = 0;
      while (!cs_n && n < 100) begin @(negedge clk); n++; end
      chk(n == 9, "R5 finish after ready", n, 9);
      chk(rx_valid && !to_err, "R5 completes", {rx_valid, to_err}, 2'b10);
    end

    // R6 wait disabled: ready line ignored.
    cfg_wait_en = 1'b0; cfg_ena_func = 1'b0; cfg_prescale = 8'd1; cfg_c2e_dly = 8'd2; ena_n = 1'b1;
    xfer(8, 16'h005A, 16'h00C3, -1, 500);
    chk(cs_low == 33 && !to_err, "R6 no wait", cs_low, 33);
    chk(rxd == 16'h00C3, "R6 rx_data", int'(rxd), 16'hC3);

    // R7 length error after second rising edge.
    cfg_wait_en = 1'b1; cfg_ena_func = 1'b1; cfg_c2e_dly = 8'd4; ena_n = 1'b0;
    xfer(8, 16'h00A5, 16'h0055, 2, 500);
    chk(cs_low == 8, "R7 cs_n released next cycle", cs_low, 8);
    chk(len_err && vcnt == 0, "R7 len_err, no valid", {len_err, vcnt[0]}, 2'b10);
    chk(!sclk && !busy, "R7 idle after abort", {sclk, busy}, 0);
    repeat (4) @(negedge clk);
    chk(len_err, "R9 len_err sticky", len_err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!len_err, "R9 len_err cleared", len_err, 0);

    // R8 ready pin not functional: mid-character release ignored.
    cfg_ena_func = 1'b0; ena_n = 1'b0;
    xfer(8, 16'h003C, 16'h0096, 2, 500);
    chk(!len_err && vcnt == 1 && rxd == 16'h0096, "R8 completes", int'(rxd), 16'h96);
    ena_n = 1'b0;

    // R10 power-down blocks start.
    power_down = 1'b1;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      int lows = 0;
      repeat (10) begin @(negedge clk); if (!cs_n || busy) lows++; end
      chk(lows == 0, "R10 start held off", lows, 0);
    end
    power_down = 1'b0;

    // R1 run enable low resets flags and blocks start.
    cfg_ena_func = 1'b1; cfg_prescale = 8'd0; cfg_c2e_dly = 8'd1; ena_n = 1'b1;
    xfer(4, 16'h0001, 16'h0000, -1, 50);
    chk(to_err, "R1 setup timeout", to_err, 1);
    run_en = 1'b0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(!to_err && cs_n && !busy, "R1 run_en low", {to_err, cs_n, busy}, 3'b010);
    run_en = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule